// File: doc/BRIEF.md
# Zero-Count Unidirectional Error Code Generator and Checker

This block protects a K-bit information word (K defaults to 8) with a separable check field that holds the binary number of 0 bits in the word. A sender uses the generated check field to build the codeword. A receiver presents the information bits and the received check field together, and the block reports whether the two agree.

The check field is a count of zeros rather than a parity, and that is what makes the check strong against unidirectional errors. If bits only fall from 1 to 0, the zero count of the information bits can only go up. The stored check value can only go down. If bits only rise from 0 to 1, both move the other way. So any corruption in a single direction, of any number of bits, leaves the two values unequal.

The verdict comes out on two rails rather than one flag. A valid word is shown as two different rail values and a failed word as two equal ones. The rail values alternate from word to word, so a rail stuck at one level shows up as an error indication.

Top module: `berger_codec`

## Requirements
- R1: `gen_chk` equals the number of 0 bits in the accepted information word, as an unsigned binary value `CW = $clog2(K+1)` bits wide (4 bits for K=8).
- R2: A word sampled with `in_valid` high at clock edge n shows its results on `gen_chk` and `err_rail` after edge n+1. `out_valid` is high for exactly that one cycle.
- R3: If the received check field equals the recomputed zero count in every bit, the two rails differ. If any bit differs, the two rails are equal.
- R4: Number the accepted words from 0 after reset. Word j drives `err_rail[1]` = j mod 2. `err_rail[0]` is the inverse of `err_rail[1]` when the word passes and equal to it when the word fails.
- R5: While `rst` is high and after its release, before any word: `out_valid` = 0, `gen_chk` = 0, `err_rail` = 2'b10.
- R6: In cycles without an accepted word, `gen_chk` and `err_rail` keep their last values, whatever the inputs do.
- R7: Every unidirectional corruption is flagged as an error (equal rails). This means any non-empty set of flipped bits across the information and check fields that are all 1→0, or all 0→1.
- R8: A mixed-direction corruption is judged only by R3. A swap of one 1 and one 0 inside the information bits is reported as a pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Information word and check field are presented this cycle |
| info_in | input | K | Information bits |
| chk_in | input | CW | Received check field |
| out_valid | output | 1 | Results for one word are present this cycle |
| gen_chk | output | CW | Zero count of the information word |
| err_rail | output | 2 | Dual-rail verdict, alternating phase |

## Verification
Both results pass through two registers: the input stage, then the output stage. They therefore appear in the second cycle after a word is driven. The bench drives each word at a falling edge and holds `in_valid` for one cycle. It samples at the second following falling edge, where `out_valid` must be high, and checks one falling edge later that the outputs held and `out_valid` dropped. The rail phase is predicted from the bench's own count of accepted words. Each expected zero count is computed by counting bits in the bench.

// File: rtl/berger_pkg.sv
package berger_pkg;
  typedef logic [1:0] rail_t;
  // Reset value of the rails: a passing pattern whose phase bit is 1,
  // so the first word (phase 0) toggles the phase rail.
  localparam rail_t RAIL_RESET = 2'b10;

  function automatic int chk_width(input int k);
    return $clog2(k + 1);
  endfunction
endpackage

// File: rtl/berger_zero_count.sv
module berger_zero_count #(
  parameter int K  = 8,
  parameter int CW = berger_pkg::chk_width(K)
) (
  input  logic [K-1:0]  word_i,
  output logic [CW-1:0] zeros_o
);
  // Running sum of zero bits, one stage per information bit.
  logic [CW-1:0] part [0:K];

  assign part[0] = '0;

  genvar gi;
  generate
    for (gi = 0; gi < K; gi++) begin : g_acc
      assign part[gi+1] = part[gi] + CW'(~word_i[gi]);
    end
  endgenerate

  assign zeros_o = part[K];
endmodule

// File: rtl/berger_rail_cmp.sv
module berger_rail_cmp #(
  parameter int CW = 4
) (
  input  logic [CW-1:0]       calc_i,
  input  logic [CW-1:0]       recv_i,
  input  logic                phase_i,
  output berger_pkg::rail_t   rail_o
);
  logic [CW-1:0] diff;
  logic          bad;

  assign diff = calc_i ^ recv_i;
  assign bad  = |diff;
  // Pass: rails differ; fail: rails equal. Rail 1 always carries the phase.
  assign rail_o = {phase_i, bad ? phase_i : ~phase_i};
endmodule

// File: rtl/berger_codec.sv
module berger_codec #(
  parameter int K  = 8,
  parameter int CW = berger_pkg::chk_width(K)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [K-1:0]  info_in,
  input  logic [CW-1:0] chk_in,
  output logic          out_valid,
  output logic [CW-1:0] gen_chk,
  output logic [1:0]    err_rail
);
  import berger_pkg::*;

  // Input stage
  logic          vld_q;
  logic [K-1:0]  info_q;
  logic [CW-1:0] chk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      info_q <= '0;
      chk_q  <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        info_q <= info_in;
        chk_q  <= chk_in;
      end
    end
  end

  logic [CW-1:0] zeros;
  rail_t         rail_d;
  logic          phase_q;

  berger_zero_count #(.K(K), .CW(CW)) u_count (
    .word_i (info_q),
    .zeros_o(zeros)
  );

  berger_rail_cmp #(.CW(CW)) u_cmp (
    .calc_i (zeros),
    .recv_i (chk_q),
    .phase_i(phase_q),
    .rail_o (rail_d)
  );

  // Output stage; phase_q is the phase the next accepted word will use.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      gen_chk   <= '0;
      err_rail  <= RAIL_RESET;
      phase_q   <= 1'b0;
    end else begin
      out_valid <= vld_q;
      if (vld_q) begin
        gen_chk  <= zeros;
        err_rail <= rail_d;
        phase_q  <= ~phase_q;
      end
    end
  end

  // Verdict agrees with the generated count versus the stored check field
  assert_verdict_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((err_rail[1] ^ err_rail[0]) == (gen_chk == $past(chk_q))));

  // Phase rail toggles on every delivered word
  assert_phase_flip_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (err_rail[1] != $past(err_rail[1])));

  // Results hold between words
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(err_rail) && $stable(gen_chk)));

  // One-cycle result strobe follows the input stage
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(vld_q));
endmodule

// File: tb/berger_codec_test.sv
module berger_codec_test;
  localparam int K  = 8;
  localparam int CW = $clog2(K + 1);
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [K-1:0]  info_in;
  logic [CW-1:0] chk_in;
  logic          out_valid;
  logic [CW-1:0] gen_chk;
  logic [1:0]    err_rail;

  int n_checks = 0;
  int n_fail   = 0;
  int n_words  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  berger_codec #(.K(K)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .info_in(info_in),
    .chk_in(chk_in), .out_valid(out_valid), .gen_chk(gen_chk),
    .err_rail(err_rail)
  );

  function automatic int zeros_of(input logic [K-1:0] w);
    int z = 0;
    for (int i = 0; i < K; i++) if (!w[i]) z++;
    return z;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one word, sample its results two edges later, then check the hold.
  task automatic apply(input logic [K-1:0] w, input logic [CW-1:0] c,
                       input int expect_err, input string req);
    int ph;
    logic [1:0] exp_rail;
    ph = n_words % 2;
    @(negedge clk);
    in_valid = 1'b1; info_in = w; chk_in = c;
    @(negedge clk);
    in_valid = 1'b0; info_in = ~w; chk_in = ~c;
    @(negedge clk);
    n_words++;
    exp_rail = {ph[0], (expect_err != 0) ? ph[0] : ~ph[0]};
    check("R2 out_valid", int'(out_valid), 1);
    check("R1 gen_chk", int'(gen_chk), zeros_of(w));
    check({req, " rails"}, int'(err_rail), int'(exp_rail));
    @(negedge clk);
    check("R2 strobe drop", int'(out_valid), 0);
    check("R6 hold", int'({gen_chk, err_rail}), int'({CW'(zeros_of(w)), exp_rail}));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [K+CW-1:0] cw, bad, mask;
    rst = 1'b1; in_valid = 1'b0; info_in = '0; chk_in = '0;
    repeat (3) @(negedge clk);
    check("R5 out_valid", int'(out_valid), 0);
    check("R5 gen_chk", int'(gen_chk), 0);
    check("R5 rails", int'(err_rail), 2);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R5 rails after release", int'(err_rail), 2);

    // Exhaustive info x check sweep (R1, R3, R4)
    for (int w = 0; w < (1 << K); w++)
      for (int c = 0; c < (1 << CW); c++)
        apply(K'(w), CW'(c), (c != zeros_of(K'(w))) ? 1 : 0, "R3 R4 sweep");

    // Unidirectional corruptions must be flagged (R7)
    for (int t = 0; t < 400; t++) begin
      logic [K-1:0] w;
      w = K'($urandom);
      cw = {w, CW'(zeros_of(w))};
      mask = (K+CW)'($urandom);
      bad = (t % 2 == 0) ? (cw & ~mask) : (cw | mask);
      apply(bad[K+CW-1:CW], bad[CW-1:0], (bad != cw) ? 1 : 0, "R7 unidirectional");
    end

    // Mixed corruptions: judged by count agreement only (R8)
    for (int t = 0; t < 200; t++) begin
      logic [K-1:0] w;
      w = K'($urandom);
      cw = {w, CW'(zeros_of(w))} ^ (K+CW)'($urandom);
      apply(cw[K+CW-1:CW], cw[CW-1:0],
            (int'(cw[CW-1:0]) != zeros_of(cw[K+CW-1:CW])) ? 1 : 0, "R8 mixed");
    end
    // Swap of one 1 and one 0 goes undetected (R8)
    apply(8'b0000_0110, CW'(zeros_of(8'b0000_0101)), 0, "R8 swap");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule